// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire bus that a target device has left mid-transfer. Such a device may still hold the data line low. One start request makes the block play a fixed waveform. The waveform is a start condition, then a train of clock pulses with the data line let go, then a repeated start, then a stop. The clock pulses give the stuck device the edges it needs to finish its byte and release the line. The stop then leaves the bus idle. The block never sends an address, so it does not depend on any device understanding a reset command.

Both lines are open-drain. The block only drives low-enables, and a released line reads high through the pull-up. The waveform is built from quarter periods of SCL. A quarter lasts `div_i + 1` clock cycles, and `div_i` is captured when a request is accepted. Every data-line change falls in the middle of an SCL low or high phase. When the sequence ends, the block samples the data line. If the line is still low, it flags the bus as stuck.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, and whenever the block is idle, both low-enables are off and `busy_o`, `done_o` and `stuck_o` are 0.
- R2: An accepted request first releases both lines for one quarter. In the next quarter SCL stays released while SDA is pulled low, which is a start condition.
- R3: After the start, the block drives PULSES (default 9) SCL pulses. Each pulse is two low quarters followed by two high quarters. SDA is released from the middle of the first pulse's low phase through the end of the last pulse.
- R4: After the last pulse comes one more SCL pulse whose second high quarter pulls SDA low (repeated start). Then comes a final pulse in which SDA stays low until the second high quarter, when it is released (stop). The full sequence is 2 + 4*(PULSES+2) quarters.
- R5: Each quarter lasts exactly `div_i + 1` clock cycles, using the value of `div_i` captured in the accepting cycle. The two low-enables never change in the same cycle.
- R6: `start_i` is accepted only while `busy_o` is 0. A request while busy has no effect on the waveform or the timing.
- R7: `busy_o` rises in the cycle after acceptance and stays 1 through the last quarter. `done_o` is a one-cycle pulse in the first cycle after the last quarter, with `busy_o` back at 0.
- R8: `stuck_o` takes the inverse of `sda_i` as sampled at the end of the last quarter. It changes together with `done_o`, holds its value until the next accepted request, and clears on that acceptance.
- R9: A synchronous reset in the middle of a sequence returns the block to idle in the next cycle, with both lines released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Recovery request, taken only when idle |
| div_i | input | DIV_W | Quarter length minus one, in clock cycles |
| sda_i | input | 1 | Sampled data-line level |
| scl_lo_o | output | 1 | Pull SCL low when 1 |
| sda_lo_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| stuck_o | output | 1 | SDA was low at the end of the sequence |

## Verification
Full sequences are run with quarter lengths of one, three and five cycles. This separates a correct quarter counter from an off-by-one, because the shortest setting has no idle count at all. One run keeps a model target holding SDA low throughout, so the stuck flag is set; the run after it shows the flag clearing on acceptance. A request pulsed in the middle of a run shows whether busy requests are ignored, and a reset mid-run shows whether the sequence is abandoned cleanly. Per-run counts of SCL rises, start-type falls and stop-type rises tell apart sequences that differ only in the number of pulses or in where SDA moves.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;

    localparam int unsigned PULSES_DEF = 9;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Released level of each line for one quarter slot (1 = released).
    typedef struct packed {
        logic scl_rel;
        logic sda_rel;
    } line_lvl_t;

    // Two start quarters plus four quarters for each pulse, Sr pulse and P pulse.
    function automatic int unsigned slot_total(int unsigned pulses);
        return 2 + 4 * (pulses + 2);
    endfunction

    function automatic line_lvl_t wave_at(int unsigned slot, int unsigned pulses);
        line_lvl_t   v;
        int unsigned t;
        int unsigned cyc;
        int unsigned q;
        if (slot < 2) begin
            v.scl_rel = 1'b1;
            v.sda_rel = (slot == 0);
        end else begin
            t         = slot - 2;
            cyc       = t / 4;
            q         = t % 4;
            v.scl_rel = (q >= 2);
            if (cyc < pulses)
                v.sda_rel = !(cyc == 0 && q == 0);
            else if (cyc == pulses)
                v.sda_rel = (q != 3);
            else
                v.sda_rel = (q == 3);
        end
        return v;
    endfunction

endpackage

// File: rtl/rcv_quarter_timer.sv
module rcv_quarter_timer #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_i,
    output logic             qend
);
    logic [DIV_W-1:0] lim_q;
    logic [DIV_W-1:0] cnt_q;

    assign qend = run && (cnt_q == lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            lim_q <= div_i;
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == lim_q)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rcv_slot_seq.sv
module rcv_slot_seq
    import i2c_rcv_pkg::*;
#(
    parameter int unsigned PULSES = PULSES_DEF,
    parameter int unsigned SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              qend,
    output logic              busy,
    output logic              accept,
    output logic              finish,
    output logic              nxt_busy,
    output logic [SLOT_W-1:0] nxt_slot
);
    localparam int unsigned       SLOT_N = slot_total(PULSES);
    localparam logic [SLOT_W-1:0] LAST   = SLOT_W'(SLOT_N - 1);

    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;

    assign busy     = (state_q == SEQ_RUN);
    assign accept   = (state_q == SEQ_IDLE) && start_i;
    assign finish   = busy && qend && (slot_q == LAST);
    assign nxt_busy = (state_d == SEQ_RUN);
    assign nxt_slot = slot_d;

    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        if (accept) begin
            state_d = SEQ_RUN;
            slot_d  = '0;
        end else if (busy && qend) begin
            if (slot_q == LAST) begin
                state_d = SEQ_IDLE;
                slot_d  = '0;
            end else begin
                slot_d = slot_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end
endmodule

// File: rtl/rcv_line_drv.sv
module rcv_line_drv
    import i2c_rcv_pkg::*;
#(
    parameter int unsigned PULSES = PULSES_DEF,
    parameter int unsigned SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nxt_busy,
    input  logic [SLOT_W-1:0] nxt_slot,
    output logic              scl_lo,
    output logic              sda_lo
);
    line_lvl_t lv;

    always_comb lv = wave_at(32'(nxt_slot), PULSES);

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_lo <= 1'b0;
            sda_lo <= 1'b0;
        end else begin
            scl_lo <= nxt_busy & ~lv.scl_rel;
            sda_lo <= nxt_busy & ~lv.sda_rel;
        end
    end
endmodule

// File: rtl/rcv_status.sv
module rcv_status (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic finish,
    input  logic sda_i,
    output logic done_o,
    output logic stuck_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done_o  <= 1'b0;
            stuck_o <= 1'b0;
        end else begin
            done_o <= finish;
            if (accept)
                stuck_o <= 1'b0;
            else if (finish)
                stuck_o <= ~sda_i;
        end
    end
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
    import i2c_rcv_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned PULSES = PULSES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             sda_i,
    output logic             scl_lo_o,
    output logic             sda_lo_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             stuck_o
);
    localparam int unsigned SLOT_N = slot_total(PULSES);
    localparam int unsigned SLOT_W = $clog2(SLOT_N);

    logic              qend;
    logic              accept;
    logic              finish;
    logic              nxt_busy;
    logic [SLOT_W-1:0] nxt_slot;

    rcv_quarter_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .run   (busy_o),
        .div_i (div_i),
        .qend  (qend)
    );

    rcv_slot_seq #(.PULSES(PULSES), .SLOT_W(SLOT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .qend     (qend),
        .busy     (busy_o),
        .accept   (accept),
        .finish   (finish),
        .nxt_busy (nxt_busy),
        .nxt_slot (nxt_slot)
    );

    rcv_line_drv #(.PULSES(PULSES), .SLOT_W(SLOT_W)) u_drv (
        .clk      (clk),
        .rst      (rst),
        .nxt_busy (nxt_busy),
        .nxt_slot (nxt_slot),
        .scl_lo   (scl_lo_o),
        .sda_lo   (sda_lo_o)
    );

    rcv_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .finish  (finish),
        .sda_i   (sda_i),
        .done_o  (done_o),
        .stuck_o (stuck_o)
    );
endmodule

// File: rtl/i2c_bus_recover_chk.sv
module i2c_bus_recover_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic sda_i,
    input logic scl_lo_o,
    input logic sda_lo_o,
    input logic busy_o,
    input logic done_o,
    input logic stuck_o
);
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!scl_lo_o && !sda_lo_o));

    assert_one_line_moves_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_lo_o) |-> $stable(scl_lo_o));

    assert_busy_needs_request_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_stuck_sample_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (stuck_o == !$past(sda_i)));

    assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_o && !scl_lo_o && !sda_lo_o && !done_o));
endmodule

bind i2c_bus_recover i2c_bus_recover_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .sda_i    (sda_i),
    .scl_lo_o (scl_lo_o),
    .sda_lo_o (sda_lo_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .stuck_o  (stuck_o)
);

// File: tb/i2c_bus_recover_bench.sv
module i2c_bus_recover_bench;
    localparam int PULSES = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] div_i = 8'd0;
    logic       slave_hold = 1'b0;
    logic       scl_lo, sda_lo, busy, done, stuck;
    wire        sda_line = !(sda_lo | slave_hold);
    wire        scl_line = !scl_lo;

    always #5 clk = ~clk;

    i2c_bus_recover u_i2c_bus_recover (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .div_i    (div_i),
        .sda_i    (sda_line),
        .scl_lo_o (scl_lo),
        .sda_lo_o (sda_lo),
        .busy_o   (busy),
        .done_o   (done),
        .stuck_o  (stuck)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Expected released levels, one entry per quarter.
    bit ref_scl[$];
    bit ref_sda[$];

    task automatic push(input bit c, input bit d);
        ref_scl.push_back(c);
        ref_sda.push_back(d);
    endtask

    initial begin
        push(1, 1); push(1, 0);
        for (int p = 0; p < PULSES; p++) begin
            push(0, p != 0); push(0, 1); push(1, 1); push(1, 1);
        end
        push(0, 1); push(0, 1); push(1, 1); push(1, 0);
        push(0, 0); push(0, 0); push(1, 0); push(1, 1);
    end

    // Behavioural reference model.
    bit m_busy = 0, m_done = 0, m_err = 0, started = 0;
    int m_k = 0, m_c = 0, m_qlen = 1;
    int cycles = 0;

    always @(posedge clk) begin
        started = 1;
        cycles++;
        if (cycles == 150000) begin
            check(0, "watchdog", cycles, 0);
            summary();
        end
        if (rst) begin
            m_busy = 0; m_done = 0; m_err = 0; m_k = 0; m_c = 0;
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (start_i) begin
                    m_busy = 1; m_k = 0; m_c = 0; m_err = 0;
                    m_qlen = int'(div_i) + 1;
                end
            end else if (m_c == m_qlen - 1) begin
                m_c = 0;
                if (m_k == ref_scl.size() - 1) begin
                    m_busy = 0; m_done = 1; m_err = !sda_line;
                end else begin
                    m_k++;
                end
            end else begin
                m_c++;
            end
        end
    end

    // Per-cycle comparison and edge tallies.
    int  n_scl_rise = 0, n_sda_fall_hi = 0, n_sda_rise_hi = 0;
    bit  p_scl = 1, p_sda = 1;

    always @(negedge clk) begin
        if (started) begin
            bit e_scl, e_sda;
            e_scl = m_busy ? !ref_scl[m_k] : 1'b0;
            e_sda = m_busy ? !ref_sda[m_k] : 1'b0;
            check(scl_lo == e_scl, "R5 scl_lo", scl_lo, e_scl);
            check(sda_lo == e_sda, "R3 sda_lo", sda_lo, e_sda);
            check(busy == m_busy, "R7 busy", busy, m_busy);
            check(done == m_done, "R7 done", done, m_done);
            check(stuck == m_err, "R8 stuck", stuck, m_err);
            if (!p_scl && scl_line) n_scl_rise++;
            if (p_scl && scl_line && p_sda && !sda_line) n_sda_fall_hi++;
            if (p_scl && scl_line && !p_sda && sda_line) n_sda_rise_hi++;
        end
        p_scl = scl_line;
        p_sda = sda_line;
    end

    task automatic run_seq(input int dv, input bit hold, input bit poke);
        @(negedge clk);
        n_scl_rise = 0; n_sda_fall_hi = 0; n_sda_rise_hi = 0;
        slave_hold = hold;
        div_i = 8'(dv);
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        check(busy == 1'b1, "R7 busy after accept", busy, 1);
        for (int i = 0; i < 10; i++) @(negedge clk);
        if (poke) begin
            start_i = 1;
            div_i = 8'd0;
            @(negedge clk);
            start_i = 0;
        end
        do @(negedge clk); while (!m_done);
        check(done == 1'b1, "R7 done pulse", done, 1);
        check(stuck == hold, "R8 stuck flag", stuck, hold);
        if (!hold) begin
            check(n_scl_rise == PULSES + 2, "R3 scl pulses", n_scl_rise, PULSES + 2);
            check(n_sda_fall_hi == 2, "R2 R4 start and repeated start", n_sda_fall_hi, 2);
            check(n_sda_rise_hi == 1, "R4 stop", n_sda_rise_hi, 1);
        end
        @(negedge clk);
        slave_hold = 0;
        check(done == 1'b0, "R7 done one cycle", done, 0);
        check(stuck == hold, "R8 stuck held", stuck, hold);
    endtask

    initial begin
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!scl_lo && !sda_lo && !busy && !done && !stuck, "R1 reset idle",
              {scl_lo, sda_lo, busy, done, stuck}, 0);

        run_seq(0, 0, 0);
        run_seq(2, 0, 0);
        run_seq(4, 1, 0);
        run_seq(1, 0, 0);
        check(stuck == 1'b0, "R8 cleared by new request", stuck, 0);
        run_seq(2, 0, 1);   // R6: request while busy ignored

        @(negedge clk);
        div_i = 8'd3;
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        for (int i = 0; i < 30; i++) @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check(!scl_lo && !sda_lo && !busy, "R9 reset mid-run",
              {scl_lo, sda_lo, busy}, 0);
        for (int i = 0; i < 5; i++) @(negedge clk);
        check(!busy && !done, "R1 idle after reset", {busy, done}, 0);

        summary();
    end
endmodule